// File: doc/BRIEF.md
# Multi-Protocol Host Bus Front End

This block sits between a host processor and the core of a display controller. It accepts byte transfers over one of three host protocols: a parallel bus with a direction pin and an enable strobe (6800 style), a parallel bus with separate active-low write and read strobes (8080 style), or a write-only two-wire serial link carried on two pins of the parallel data bus. A static mode input picks the protocol. A two-pin chip select qualifies all activity. One pin is active low and the other is active high.

Every written byte leaves on `wr_byte` together with a single-cycle strobe. The strobe is `cmd_stb` when the data/command line was low, and `dat_stb` when it was high. On a parallel read, the block raises `bus_oe` so that an external pad can drive `bus_o`, which carries the byte the core supplies on `rd_byte`. All bus pins are synchronized to `clk` before edges are detected. The asynchronous active-low reset takes effect at once and is released synchronously.

Top module: `hif_front`

## Requirements
- R1: Transfers and reads take effect only when `sel_n` is low and `sel_p` is high at the same time. Under any other combination, no strobe fires, `wr_byte` keeps its value and `bus_oe` stays low.
- R2: A completed write raises `dat_stb` when `dc` was high and `cmd_stb` when `dc` was low. The two strobes never fire together, and `wr_byte` takes the written byte.
- R3: With `bus_mode` = 00 (6800 style), a write happens when `en_rd` falls while `rw_wr` is low. The byte on `bus_i` at that edge is the one written.
- R4: With `bus_mode` = 00, `bus_oe` is high while `rw_wr` and `en_rd` are both high. A falling `en_rd` with `rw_wr` high writes nothing. `bus_o` equals `rd_byte` while `bus_oe` is high and is zero otherwise.
- R5: With `bus_mode` = 01 (8080 style), a write happens on the rising edge of the active-low write strobe `rw_wr`, and the byte on `bus_i` is the one written.
- R6: With `bus_mode` = 01, `bus_oe` is high while the active-low read strobe `en_rd` is low.
- R7: With `bus_mode[1]` = 1 (serial), `bus_i[6]` is the serial clock and `bus_i[7]` is the serial data. Each rising serial clock shifts in one bit, MSB first. The eighth bit completes the byte, and `dc` is taken at that eighth edge.
- R8: In serial mode `bus_oe` stays low, whatever `rw_wr` and `en_rd` do.
- R9: Deselecting the chip in the middle of a serial byte discards the bits shifted in so far. The next byte starts again from its first bit.
- R10: A low `rst_n` of any length clears the strobes, `bus_oe` and `wr_byte` at once, without waiting for a clock. It also discards partly shifted serial bits.
- R11: Each strobe lasts one clock cycle. A strobe, and every change of `bus_oe`, appears SYNC_STAGES+1 clock edges after the causing pin change (3 edges at the default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 2 | Protocol: 00 6800 style, 01 8080 style, 1x serial |
| sel_n | input | 1 | Chip select, active low |
| sel_p | input | 1 | Chip select, active high |
| dc | input | 1 | Data (high) or command (low) |
| rw_wr | input | 1 | 6800: read (high) / write (low); 8080: active-low write strobe |
| en_rd | input | 1 | 6800: enable, active high; 8080: active-low read strobe |
| bus_i | input | 8 | Data bus input; serial data on bit 7, serial clock on bit 6 |
| rd_byte | input | 8 | Byte supplied by the core for reads |
| bus_o | output | 8 | Data bus output value |
| bus_oe | output | 1 | Data bus output enable |
| cmd_stb | output | 1 | One-cycle command byte strobe |
| dat_stb | output | 1 | One-cycle display data byte strobe |
| wr_byte | output | 8 | Last written byte |

## Verification
The pin synchronizer, the edge detector and the output register place every strobe, and every rise or fall of `bus_oe`, on the third clock edge after the pin change at the default depth. The bench changes inputs on falling clock edges and counts the falling edges that follow. A write is watched over a six-edge window, which must hold exactly one strobe, of the right kind, at the third sample. For reads, the bench confirms that `bus_oe` is still low at the second sample and has risen by the third. The reset check samples in the middle of a sub-cycle reset pulse, because the clear must not wait for a clock edge.

// File: rtl/hif_pkg.sv
package hif_pkg;

  localparam int DATA_W = 8;
  localparam int SER_DAT_BIT = DATA_W - 1;
  localparam int SER_CLK_BIT = DATA_W - 2;

  typedef enum logic [1:0] {
    BUS_M68  = 2'b00,
    BUS_I80  = 2'b01,
    BUS_SER  = 2'b10,
    BUS_SERX = 2'b11
  } bus_mode_e;

  typedef struct packed {
    logic              sel_n;
    logic              sel_p;
    logic              dc;
    logic              ctl_a;
    logic              ctl_b;
    logic [DATA_W-1:0] dq;
  } pin_bundle_t;

  localparam int PIN_W = $bits(pin_bundle_t);

  // Idle value after reset: deselected, all strobes low.
  localparam pin_bundle_t PIN_IDLE = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, {DATA_W{1'b0}}};

endpackage

// File: rtl/hif_sync.sv
module hif_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_n;

  always_comb begin
    stg_n[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      stg_n[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= stg_n;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/hif_par.sv
module hif_par (
  input  logic clk,
  input  logic rst_n,
  input  logic m68,
  input  logic sel,
  input  logic ctl_a,
  input  logic ctl_b,
  output logic fire,
  output logic rd_qual
);

  // ctl_a: 6800 direction / 8080 write strobe (low active)
  // ctl_b: 6800 enable / 8080 read strobe (low active)
  logic a_q, b_q;
  logic a_rise, b_fall;

  always_comb begin
    a_rise = ctl_a & ~a_q;
    b_fall = b_q & ~ctl_b;
    if (m68) begin
      fire    = sel & b_fall & ~ctl_a;
      rd_qual = sel & ctl_a & ctl_b;
    end else begin
      fire    = sel & a_rise;
      rd_qual = sel & ~ctl_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= ctl_a;
      b_q <= ctl_b;
    end
  end

endmodule

// File: rtl/hif_ser.sv
module hif_ser
  import hif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sel,
  input  logic              sclk,
  input  logic              sdat,
  input  logic              dc,
  output logic              fire,
  output logic              fire_dc,
  output logic [DATA_W-1:0] fire_byte
);

  localparam int CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic              sclk_q;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              rise;

  always_comb begin
    rise      = sclk & ~sclk_q;
    sh_n      = sh_q;
    cnt_n     = cnt_q;
    fire      = 1'b0;
    fire_dc   = dc;
    fire_byte = {sh_q[DATA_W-2:0], sdat};
    if (!active || !sel) begin
      sh_n  = '0;
      cnt_n = '0;
    end else if (rise) begin
      sh_n = {sh_q[DATA_W-2:0], sdat};
      if (cnt_q == LAST) begin
        fire  = 1'b1;
        cnt_n = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else begin
      sclk_q <= sclk;
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
    end
  end

endmodule

// File: rtl/hif_front.sv
module hif_front
  import hif_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_mode,
  input  logic              sel_n,
  input  logic              sel_p,
  input  logic              dc,
  input  logic              rw_wr,
  input  logic              en_rd,
  input  logic [DATA_W-1:0] bus_i,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe,
  output logic              cmd_stb,
  output logic              dat_stb,
  output logic [DATA_W-1:0] wr_byte
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [RST_STAGES-1:0] rst_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= '0;
    end else begin
      rst_q <= {rst_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_q[RST_STAGES-1];

  // Pin synchronization.
  pin_bundle_t pins_raw, pins_syn;

  assign pins_raw = '{sel_n, sel_p, dc, rw_wr, en_rd, bus_i};

  hif_sync #(
    .W      (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    (pins_raw),
    .q    (pins_syn)
  );

  logic sel, ser_mode, m68;

  assign sel      = ~pins_syn.sel_n & pins_syn.sel_p;
  assign ser_mode = (bus_mode == BUS_SER) || (bus_mode == BUS_SERX);
  assign m68      = (bus_mode == BUS_M68);

  // Parallel protocols.
  logic par_fire, par_rd;

  hif_par u_par (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .m68    (m68),
    .sel    (sel),
    .ctl_a  (pins_syn.ctl_a),
    .ctl_b  (pins_syn.ctl_b),
    .fire   (par_fire),
    .rd_qual(par_rd)
  );

  // Serial protocol.
  logic              ser_fire, ser_dc;
  logic [DATA_W-1:0] ser_byte;

  hif_ser u_ser (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .active   (ser_mode),
    .sel      (sel),
    .sclk     (pins_syn.dq[SER_CLK_BIT]),
    .sdat     (pins_syn.dq[SER_DAT_BIT]),
    .dc       (pins_syn.dc),
    .fire     (ser_fire),
    .fire_dc  (ser_dc),
    .fire_byte(ser_byte)
  );

  // Output stage: next state.
  logic              fire, fire_dc;
  logic [DATA_W-1:0] fire_byte;
  logic              cmd_n, dat_n, oe_n;
  logic [DATA_W-1:0] byte_n;
  logic              cmd_q, dat_q, oe_q;
  logic [DATA_W-1:0] byte_q;

  always_comb begin
    if (ser_mode) begin
      fire      = ser_fire;
      fire_dc   = ser_dc;
      fire_byte = ser_byte;
    end else begin
      fire      = par_fire;
      fire_dc   = pins_syn.dc;
      fire_byte = pins_syn.dq;
    end
    cmd_n  = fire & ~fire_dc;
    dat_n  = fire & fire_dc;
    byte_n = fire ? fire_byte : byte_q;
    oe_n   = par_rd & ~ser_mode;
  end

  // Output stage: registers.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cmd_q  <= 1'b0;
      dat_q  <= 1'b0;
      oe_q   <= 1'b0;
      byte_q <= '0;
    end else begin
      cmd_q  <= cmd_n;
      dat_q  <= dat_n;
      oe_q   <= oe_n;
      byte_q <= byte_n;
    end
  end

  assign cmd_stb = cmd_q;
  assign dat_stb = dat_q;
  assign bus_oe  = oe_q;
  assign wr_byte = byte_q;
  assign bus_o   = oe_q ? rd_byte : '0;

endmodule

// File: rtl/hif_front_chk.sv
module hif_front_chk
  import hif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_mode,
  input logic       sel_n,
  input logic       sel_p,
  input logic       cmd_stb,
  input logic       dat_stb,
  input logic       bus_oe
);

  // History of the raw chip-select qualification, one entry per edge.
  logic [SYNC_STAGES:0] sel_h;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_h <= '0;
    end else begin
      sel_h <= {sel_h[SYNC_STAGES-1:0], (~sel_n & sel_p)};
    end
  end

  logic ser;
  assign ser = (bus_mode == BUS_SER) || (bus_mode == BUS_SERX);

  assert_sel_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb || dat_stb || bus_oe) |-> sel_h[SYNC_STAGES])
    else $error("output active without chip select");

  assert_stb_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_stb && dat_stb))
    else $error("both strobes high");

  assert_cmd_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb)
    else $error("command strobe longer than one cycle");

  assert_dat_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dat_stb |=> !dat_stb)
    else $error("data strobe longer than one cycle");

  assert_ser_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ser && $past(ser)) |-> !bus_oe)
    else $error("output enable in serial mode");

endmodule

bind hif_front hif_front_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_mode(bus_mode),
  .sel_n   (sel_n),
  .sel_p   (sel_p),
  .cmd_stb (cmd_stb),
  .dat_stb (dat_stb),
  .bus_oe  (bus_oe)
);

// File: tb/sim_hif_front.sv
`timescale 1ns/1ps
module sim_hif_front;

  localparam int LAT = 3;
  localparam int WIN = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_mode;
  logic       sel_n, sel_p, dc, rw_wr, en_rd;
  logic [7:0] bus_i, rd_byte;
  logic [7:0] bus_o, wr_byte;
  logic       bus_oe, cmd_stb, dat_stb;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;
  logic [7:0] last_b = 8'h00;

  always #2.5 clk = ~clk;

  hif_front u0 (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .sel_n(sel_n), .sel_p(sel_p),
    .dc(dc), .rw_wr(rw_wr), .en_rd(en_rd), .bus_i(bus_i), .rd_byte(rd_byte),
    .bus_o(bus_o), .bus_oe(bus_oe), .cmd_stb(cmd_stb), .dat_stb(dat_stb),
    .wr_byte(wr_byte)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Watch a window after the causing edge: count strobes, their cycle, the byte.
  task automatic watch(input bit fire, input bit wdc, input logic [7:0] b, input string req);
    int nc = 0;
    int nd = 0;
    int at = 0;
    for (int i = 1; i <= WIN; i++) begin
      @(negedge clk);
      if (cmd_stb) begin nc++; at = i; end
      if (dat_stb) begin nd++; at = i; end
    end
    check({req, " cmd strobes"}, nc, (fire && !wdc) ? 1 : 0);
    check({req, " data strobes"}, nd, (fire && wdc) ? 1 : 0);
    if (fire) check({req, " latency R11"}, at, LAT);
    check({req, " byte"}, wr_byte, fire ? b : last_b);
    if (fire) last_b = b;
  endtask

  task automatic set_mode(input logic [1:0] m);
    sel_n = 1'b1; sel_p = 1'b0; bus_i = 8'h00;
    case (m)
      2'b00:   begin rw_wr = 1'b1; en_rd = 1'b0; end
      2'b01:   begin rw_wr = 1'b1; en_rd = 1'b1; end
      default: begin rw_wr = 1'b0; en_rd = 1'b0; end
    endcase
    bus_mode = m;
    wait_n(6);
  endtask

  task automatic select(input logic sn, input logic sp);
    sel_n = sn; sel_p = sp;
    wait_n(4);
  endtask

  task automatic m68_write(input logic d, input logic [7:0] b);
    dc = d; rw_wr = 1'b0; bus_i = b;
    wait_n(4);
    en_rd = 1'b1;
    wait_n(4);
    en_rd = 1'b0;
  endtask

  task automatic i80_write(input logic d, input logic [7:0] b);
    dc = d; bus_i = b; rw_wr = 1'b0;
    wait_n(4);
    rw_wr = 1'b1;
  endtask

  task automatic ser_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      bus_i[6] = 1'b0;
      bus_i[7] = b[7-i];
      wait_n(3);
      bus_i[6] = 1'b1;
      if (i != n - 1) wait_n(3);
    end
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #750000;
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic       d, sn, sp, selok;
    logic [1:0] m;
    void'($urandom(32'h0005EED5));
    rst_n = 1'b0; bus_mode = 2'b00; sel_n = 1'b1; sel_p = 1'b0; dc = 1'b0;
    rw_wr = 1'b1; en_rd = 1'b0; bus_i = 8'h00; rd_byte = 8'h00;
    wait_n(3);
    check("R10 reset cmd_stb", cmd_stb, 0);
    check("R10 reset dat_stb", dat_stb, 0);
    check("R10 reset bus_oe", bus_oe, 0);
    check("R10 reset wr_byte", wr_byte, 0);
    check("R4 reset bus_o", bus_o, 0);
    rst_n = 1'b1;
    wait_n(4);

    // 6800 style writes and read
    set_mode(2'b00); select(1'b0, 1'b1);
    m68_write(1'b0, 8'hA5); watch(1'b1, 1'b0, 8'hA5, "R3 m68 command");
    rw_wr = 1'b1;
    m68_write(1'b1, 8'h3C); watch(1'b1, 1'b1, 8'h3C, "R2 m68 data");
    rw_wr = 1'b1; rd_byte = 8'h96;
    wait_n(2);
    en_rd = 1'b1;
    wait_n(LAT - 1);
    check("R11 oe not yet", bus_oe, 0);
    wait_n(1);
    check("R4 m68 read oe", bus_oe, 1);
    check("R4 m68 read data", bus_o, 8'h96);
    en_rd = 1'b0;
    watch(1'b0, 1'b0, 8'h00, "R4 m68 read end no write");
    check("R4 m68 oe released", bus_oe, 0);
    check("R4 bus_o zero", bus_o, 0);

    // 8080 style writes and read
    set_mode(2'b01); select(1'b0, 1'b1);
    i80_write(1'b0, 8'h5E); watch(1'b1, 1'b0, 8'h5E, "R5 i80 command");
    i80_write(1'b1, 8'hE1); watch(1'b1, 1'b1, 8'hE1, "R5 i80 data");
    rd_byte = 8'h4B;
    en_rd = 1'b0;
    wait_n(LAT);
    check("R6 i80 read oe", bus_oe, 1);
    check("R6 i80 read data", bus_o, 8'h4B);
    en_rd = 1'b1;
    wait_n(LAT);
    check("R6 i80 oe released", bus_oe, 0);

    // Deselected: ignored
    select(1'b1, 1'b1);
    i80_write(1'b1, 8'h77); watch(1'b0, 1'b1, 8'h00, "R1 deselected write");
    en_rd = 1'b0;
    wait_n(LAT + 1);
    check("R1 deselected read oe", bus_oe, 0);
    en_rd = 1'b1;

    // Serial
    set_mode(2'b10); select(1'b0, 1'b1);
    dc = 1'b1; ser_bits(8'hC3, 8); watch(1'b1, 1'b1, 8'hC3, "R7 serial data");
    dc = 1'b0; ser_bits(8'h5A, 8); watch(1'b1, 1'b0, 8'h5A, "R7 serial command");
    bus_i[6] = 1'b0;
    rw_wr = 1'b1; en_rd = 1'b1;
    wait_n(5);
    check("R8 serial oe 6800 pattern", bus_oe, 0);
    en_rd = 1'b0; rw_wr = 1'b0;
    wait_n(5);
    check("R8 serial oe 8080 pattern", bus_oe, 0);

    dc = 1'b1; ser_bits(8'hFF, 4); watch(1'b0, 1'b1, 8'h00, "R9 partial no strobe");
    bus_i[6] = 1'b0;
    select(1'b1, 1'b0); select(1'b0, 1'b1);
    ser_bits(8'h12, 8); watch(1'b1, 1'b1, 8'h12, "R9 fresh byte after deselect");

    bus_i[6] = 1'b0;
    ser_bits(8'hF0, 5);
    bus_i[6] = 1'b0;
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check("R10 async clear wr_byte", wr_byte, 0);
    check("R10 async clear strobes", {cmd_stb, dat_stb, bus_oe}, 0);
    #0.5 rst_n = 1'b1;
    last_b = 8'h00;
    wait_n(6);
    ser_bits(8'h81, 8); watch(1'b1, 1'b1, 8'h81, "R10 byte after reset");
    bus_i[6] = 1'b0;

    // Constrained random mix
    for (int t = 0; t < 48; t++) begin
      m = 2'($urandom % 3);
      set_mode(m);
      if (($urandom % 3) != 0) begin sn = 1'b0; sp = 1'b1; end
      else begin sn = 1'($urandom); sp = 1'($urandom); end
      selok = !sn && sp;
      select(sn, sp);
      d = 1'($urandom);
      b = 8'($urandom);
      case (m)
        2'b00: begin m68_write(d, b); watch(selok, d, b, "R1 R3 random m68"); rw_wr = 1'b1; end
        2'b01: begin i80_write(d, b); watch(selok, d, b, "R1 R5 random i80"); end
        default: begin dc = d; ser_bits(b, 8); watch(selok, d, b, "R1 R7 random serial"); bus_i[6] = 1'b0; end
      endcase
      if (m != 2'b10) begin
        rd_byte = 8'($urandom);
        if (m == 2'b00) begin rw_wr = 1'b1; en_rd = 1'b1; end
        else en_rd = 1'b0;
        wait_n(LAT + 1);
        check("R1 random read oe", bus_oe, selok);
        check("R4 random read bus_o", bus_o, selok ? rd_byte : 8'h00);
        if (m == 2'b00) en_rd = 1'b0;
        else en_rd = 1'b1;
        wait_n(LAT + 1);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule